// File: doc/BRIEF.md
# Fused Integer ALU

This block is the integer arithmetic and logic unit of a 64-bit execution pipeline. It takes a 7-bit operation code together with two 64-bit source operands. One clock edge later it returns a 64-bit result.

The operation code carries its group in bits [6:4]:

- 000: shifts and single-bit operations.
- 001: 32-bit word operations.
- 010: the add family.
- 011: subtract and compare.
- 100 and 101: plain logic, sign extension and packing.
- 110: logic results narrowed to one bit or to a halfword.

Besides the usual operations, the block executes several fused macro-operations that a decoder may form from instruction pairs:

- An add of only the low bit of the first source.
- Adds of the first source shifted right by 29 to 32.
- An upper-immediate-plus-low-immediate add.
- Logic operations whose result is cut down to a single bit or a zero-extended halfword.

Three sub-units decode the code in parallel: a shift unit, an arithmetic unit and a logic unit. Each unit claims the codes it owns and returns zero for all others. The top ORs their outputs and registers the sum.

A code that no unit claims yields zero.

Top module: `fused_int_alu`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock edge, and `out_result` is the result of the operands presented at that edge. A synchronous active-low reset clears both outputs to zero.
- R2: While `in_valid` is low, `out_result` keeps its last value and `out_valid` is low, whatever `in_op` and the sources carry.
- R3: Shifts and rotates use `in_src2[5:0]` as the amount:
  - 0000001 shifts left; 0000101 shifts right logically; 0000111 shifts right arithmetically.
  - 0001001 rotates left; 0001011 rotates right.
  - 0000000 shifts the zero-extended `in_src1[31:0]` left.
- R4: Single-bit operations index the bit with `in_src2[5:0]`:
  - 0000010 clears that bit of `in_src1`.
  - 0000011 sets it.
  - 0000100 inverts it.
  - 0000110 returns it in bit 0, with all other bits zero.
- R5: Word operations compute a 32-bit value and sign-extend it to 64 bits. Shift and rotate amounts come from `in_src2[4:0]`.
  - 0010000 adds; 0010010 subtracts.
  - 0010001 adds `in_src1[0]` to `in_src2`.
  - 0011000 shifts left; 0011001 shifts right logically; 0011010 shifts right arithmetically.
  - 0011100 rotates left; 0011101 rotates right.
- R6: Narrowed word sums, zero-extended unless stated:
  - 0010100 returns bit 0 of `in_src1+in_src2`.
  - 0010101 returns bits [7:0].
  - 0010110 returns bits [15:0].
  - 0010111 returns bits [15:0] sign-extended.
- R7: Add family:
  - 0100001: `src1+src2`.
  - 0100000: zero-extended `src1[31:0]+src2`.
  - 0100010: `src1[0]+src2`.
  - 0100100 to 0100111: `(src1>>29+k)+src2`, with k = `in_op[1:0]` and a logical shift.
- R8: Shift-and-add: `(src1<<N)+src2`. Codes 0101001, 0101011, 0101101 and 0101111 give N = 1, 2, 3 and 4. Codes 0101000, 0101010 and 0101100 give N = 1, 2 and 3, with `src1[31:0]` zero-extended first.
- R9: Immediate-pair adds:
  - 0100011 returns the sign-extended `src2[11:0]` plus `src2` with bits [11:0] cleared.
  - 0010011 does the same on 32 bits and sign-extends the 32-bit sum.
- R10: Subtract and compare, taken from `src1-src2`:
  - 0110000 returns the difference.
  - 0110001 returns 1 when `src1 < src2` unsigned, else 0; 0110010 does the same for the signed order.
  - 0110100 returns the unsigned maximum; 0110101 the unsigned minimum.
  - 0110110 returns the signed maximum; 0110111 the signed minimum.
- R11: Logic and packing:
  - Logic: 1000000 and; 1000001 `src1&~src2`; 1000010 or; 1000011 `src1|~src2`; 1000100 xor; 1000101 xnor.
  - 1000110 sets each byte of `src1` to FF if it is nonzero, else 00.
  - Sign extension: 1001000 sign-extends byte 0 of `src1`; 1001010 sign-extends its halfword 0.
  - Packing: 1001001 returns `{src2[7:0],src1[7:0]}` zero-extended; 1001011 returns `{src2[15:0],src1[15:0]}` sign-extended; 1010010 returns `{src2[31:0],src1[31:0]}`.
  - Reversal: 1010000 reverses the bits inside each byte of `src1`; 1010001 reverses the byte order.
- R12: Codes 110xyzw take a base operation from `xyz`: 000 and, 001 or, 010 xor, 011 the byte-wise OR-combine of `src1`. With `w`=0 the result is bit 0 of the base result only. With `w`=1 it is bits [15:0] of the base result, zero-extended.
- R13: Every code not listed above returns zero, for example 0001000, 0101110, 1010011, 1101000 and 1111111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and code are presented this cycle |
| in_op | input | 7 | Operation code |
| in_src1 | input | 64 | First source operand |
| in_src2 | input | 64 | Second source operand, or shift amount or bit index |
| out_valid | output | 1 | A result is present |
| out_result | output | 64 | Registered result |

## Verification
Every one of the 128 operation codes is driven with several operand pairs and compared against a behavioural model of the requirements:

- All-zero and all-one operands expose stuck sign-extension and the narrowing masks.
- Pairs with opposite signs separate the signed compares from the unsigned ones.
- Random pairs cover the general arithmetic.
- Shift amounts wider than five or six bits show that only the low index bits are honoured.

Directed vectors pin down the values that random data seldom reaches:

- A word arithmetic shift of bit 31.
- An immediate-pair add with a negative low immediate.
- A shift-right-by-32 add.
- The halfword sign step at 0x7FFF+1.

Separate sequences check output hold with `in_valid` low, and a reset in the middle of traffic.

// File: rtl/fused_alu_pkg.sv
package fused_alu_pkg;

   localparam int OPC_W      = 7;
   localparam int IMM_LO_W   = 12;
   localparam int SRADD_BASE = 29;

   typedef logic [OPC_W-1:0] opc_t;

   // group field, bits [6:4]
   typedef enum logic [2:0] {
      GRP_SHIFT = 3'b000,
      GRP_WORD  = 3'b001,
      GRP_ADD   = 3'b010,
      GRP_CMP   = 3'b011,
      GRP_LOGIC = 3'b100,
      GRP_PACK  = 3'b101,
      GRP_NARROW= 3'b110
   } opc_grp_e;

   // shift / single bit
   localparam opc_t OPC_SLL_UW  = 7'b000_0000;
   localparam opc_t OPC_SLL     = 7'b000_0001;
   localparam opc_t OPC_BITCLR  = 7'b000_0010;
   localparam opc_t OPC_BITSET  = 7'b000_0011;
   localparam opc_t OPC_BITINV  = 7'b000_0100;
   localparam opc_t OPC_SRL     = 7'b000_0101;
   localparam opc_t OPC_BITGET  = 7'b000_0110;
   localparam opc_t OPC_SRA     = 7'b000_0111;
   localparam opc_t OPC_ROTL    = 7'b000_1001;
   localparam opc_t OPC_ROTR    = 7'b000_1011;
   // word
   localparam opc_t OPC_W_ADD   = 7'b001_0000;
   localparam opc_t OPC_W_ODD   = 7'b001_0001;
   localparam opc_t OPC_W_SUB   = 7'b001_0010;
   localparam opc_t OPC_W_IMMP  = 7'b001_0011;
   localparam opc_t OPC_W_SUMB0 = 7'b001_0100;
   localparam opc_t OPC_W_SUMBY = 7'b001_0101;
   localparam opc_t OPC_W_SUMZH = 7'b001_0110;
   localparam opc_t OPC_W_SUMSH = 7'b001_0111;
   localparam opc_t OPC_W_SLL   = 7'b001_1000;
   localparam opc_t OPC_W_SRL   = 7'b001_1001;
   localparam opc_t OPC_W_SRA   = 7'b001_1010;
   localparam opc_t OPC_W_ROTL  = 7'b001_1100;
   localparam opc_t OPC_W_ROTR  = 7'b001_1101;
   // add family
   localparam opc_t OPC_ADD_UW  = 7'b010_0000;
   localparam opc_t OPC_ADD     = 7'b010_0001;
   localparam opc_t OPC_ODD_ADD = 7'b010_0010;
   localparam opc_t OPC_IMMP    = 7'b010_0011;
   localparam opc_t OPC_SR29    = 7'b010_0100;
   localparam opc_t OPC_SR30    = 7'b010_0101;
   localparam opc_t OPC_SR31    = 7'b010_0110;
   localparam opc_t OPC_SR32    = 7'b010_0111;
   localparam opc_t OPC_SH1_UW  = 7'b010_1000;
   localparam opc_t OPC_SH1     = 7'b010_1001;
   localparam opc_t OPC_SH2_UW  = 7'b010_1010;
   localparam opc_t OPC_SH2     = 7'b010_1011;
   localparam opc_t OPC_SH3_UW  = 7'b010_1100;
   localparam opc_t OPC_SH3     = 7'b010_1101;
   localparam opc_t OPC_SH4     = 7'b010_1111;
   // subtract / compare
   localparam opc_t OPC_SUB     = 7'b011_0000;
   localparam opc_t OPC_LT_U    = 7'b011_0001;
   localparam opc_t OPC_LT_S    = 7'b011_0010;
   localparam opc_t OPC_MAX_U   = 7'b011_0100;
   localparam opc_t OPC_MIN_U   = 7'b011_0101;
   localparam opc_t OPC_MAX_S   = 7'b011_0110;
   localparam opc_t OPC_MIN_S   = 7'b011_0111;
   // logic / pack
   localparam opc_t OPC_AND     = 7'b100_0000;
   localparam opc_t OPC_ANDNOT  = 7'b100_0001;
   localparam opc_t OPC_OR      = 7'b100_0010;
   localparam opc_t OPC_ORNOT   = 7'b100_0011;
   localparam opc_t OPC_XOR     = 7'b100_0100;
   localparam opc_t OPC_XNOR    = 7'b100_0101;
   localparam opc_t OPC_BYTEOR  = 7'b100_0110;
   localparam opc_t OPC_SEXT8   = 7'b100_1000;
   localparam opc_t OPC_PACK8   = 7'b100_1001;
   localparam opc_t OPC_SEXT16  = 7'b100_1010;
   localparam opc_t OPC_PACK16  = 7'b100_1011;
   localparam opc_t OPC_BITREV  = 7'b101_0000;
   localparam opc_t OPC_BYTEREV = 7'b101_0001;
   localparam opc_t OPC_PACK32  = 7'b101_0010;

endpackage

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
   import fused_alu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  opc_t                      op,
   input  logic [DATA_W-1:0]         src1,
   input  logic [$clog2(DATA_W)-1:0] amt,
   output logic                      hit,
   output logic [DATA_W-1:0]         res
);
   localparam int SH_W   = $clog2(DATA_W);
   localparam int HALF_W = DATA_W / 2;
   localparam int WSH_W  = $clog2(HALF_W);

   logic [HALF_W-1:0] w_src;
   logic [WSH_W-1:0]  w_amt;
   logic [DATA_W-1:0] bit_sel;
   logic [DATA_W-1:0] rot_l, rot_r;
   logic [HALF_W-1:0] w_rot_l, w_rot_r, w_res;
   logic              w_sel;

   assign w_src   = src1[HALF_W-1:0];
   assign w_amt   = amt[WSH_W-1:0];
   assign bit_sel = {{(DATA_W-1){1'b0}}, 1'b1} << amt;

   // rotate built from two shifts; amount 0 makes the second shift by full width yield 0
   assign rot_l   = (src1 << amt) | (src1 >> ((SH_W+1)'(DATA_W) - (SH_W+1)'(amt)));
   assign rot_r   = (src1 >> amt) | (src1 << ((SH_W+1)'(DATA_W) - (SH_W+1)'(amt)));
   assign w_rot_l = (w_src << w_amt) | (w_src >> ((WSH_W+1)'(HALF_W) - (WSH_W+1)'(w_amt)));
   assign w_rot_r = (w_src >> w_amt) | (w_src << ((WSH_W+1)'(HALF_W) - (WSH_W+1)'(w_amt)));

   always_comb begin
      w_sel = 1'b1;
      unique case (op)
         OPC_W_SLL:  w_res = w_src << w_amt;
         OPC_W_SRL:  w_res = w_src >> w_amt;
         OPC_W_SRA:  w_res = $signed(w_src) >>> w_amt;
         OPC_W_ROTL: w_res = w_rot_l;
         OPC_W_ROTR: w_res = w_rot_r;
         default: begin
            w_res = '0;
            w_sel = 1'b0;
         end
      endcase
   end

   always_comb begin
      hit = 1'b1;
      res = '0;
      unique case (op)
         OPC_SLL_UW: res = {{(DATA_W-HALF_W){1'b0}}, w_src} << amt;
         OPC_SLL:    res = src1 << amt;
         OPC_SRL:    res = src1 >> amt;
         OPC_SRA:    res = $signed(src1) >>> amt;
         OPC_BITCLR: res = src1 & ~bit_sel;
         OPC_BITSET: res = src1 | bit_sel;
         OPC_BITINV: res = src1 ^ bit_sel;
         OPC_BITGET: res = {{(DATA_W-1){1'b0}}, |(src1 & bit_sel)};
         OPC_ROTL:   res = rot_l;
         OPC_ROTR:   res = rot_r;
         default: begin
            hit = w_sel;
            res = w_sel ? {{(DATA_W-HALF_W){w_res[HALF_W-1]}}, w_res} : '0;
         end
      endcase
   end

endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
   import fused_alu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  opc_t              op,
   input  logic [DATA_W-1:0] src1,
   input  logic [DATA_W-1:0] src2,
   output logic              hit,
   output logic [DATA_W-1:0] res
);
   localparam int HALF_W = DATA_W / 2;
   localparam int HW_W   = 16;
   localparam int BY_W   = 8;

   logic [DATA_W-1:0] sum, odd_sum, uw_src1, imm_pair, sr_sum;
   logic [DATA_W:0]   diff;
   logic [HALF_W-1:0] w_imm_pair;
   logic              lt_u, lt_s;

   function automatic logic [DATA_W-1:0] sx_half(input logic [HALF_W-1:0] v);
      return {{(DATA_W-HALF_W){v[HALF_W-1]}}, v};
   endfunction

   assign sum     = src1 + src2;
   assign odd_sum = src2 + {{(DATA_W-1){1'b0}}, src1[0]};
   assign uw_src1 = {{(DATA_W-HALF_W){1'b0}}, src1[HALF_W-1:0]};
   assign diff    = {1'b0, src1} - {1'b0, src2};

   // compare results taken from the subtractor: borrow gives unsigned order
   assign lt_u = diff[DATA_W];
   assign lt_s = (src1[DATA_W-1] ^ src2[DATA_W-1]) ? src1[DATA_W-1] : diff[DATA_W-1];

   assign imm_pair   = {{(DATA_W-IMM_LO_W){src2[IMM_LO_W-1]}}, src2[IMM_LO_W-1:0]}
                     + {src2[DATA_W-1:IMM_LO_W], {IMM_LO_W{1'b0}}};
   assign w_imm_pair = {{(HALF_W-IMM_LO_W){src2[IMM_LO_W-1]}}, src2[IMM_LO_W-1:0]}
                     + {src2[HALF_W-1:IMM_LO_W], {IMM_LO_W{1'b0}}};

   // code bits [1:0] select the right-shift distance above the base
   assign sr_sum = (src1 >> (SRADD_BASE + int'(op[1:0]))) + src2;

   always_comb begin
      hit = 1'b1;
      res = '0;
      unique case (op)
         OPC_W_ADD:   res = sx_half(sum[HALF_W-1:0]);
         OPC_W_ODD:   res = sx_half(odd_sum[HALF_W-1:0]);
         OPC_W_SUB:   res = sx_half(diff[HALF_W-1:0]);
         OPC_W_IMMP:  res = sx_half(w_imm_pair);
         OPC_W_SUMB0: res = {{(DATA_W-1){1'b0}}, sum[0]};
         OPC_W_SUMBY: res = {{(DATA_W-BY_W){1'b0}}, sum[BY_W-1:0]};
         OPC_W_SUMZH: res = {{(DATA_W-HW_W){1'b0}}, sum[HW_W-1:0]};
         OPC_W_SUMSH: res = {{(DATA_W-HW_W){sum[HW_W-1]}}, sum[HW_W-1:0]};
         OPC_ADD_UW:  res = uw_src1 + src2;
         OPC_ADD:     res = sum;
         OPC_ODD_ADD: res = odd_sum;
         OPC_IMMP:    res = imm_pair;
         OPC_SR29, OPC_SR30, OPC_SR31, OPC_SR32: res = sr_sum;
         OPC_SH1_UW:  res = (uw_src1 << 1) + src2;
         OPC_SH1:     res = (src1 << 1) + src2;
         OPC_SH2_UW:  res = (uw_src1 << 2) + src2;
         OPC_SH2:     res = (src1 << 2) + src2;
         OPC_SH3_UW:  res = (uw_src1 << 3) + src2;
         OPC_SH3:     res = (src1 << 3) + src2;
         OPC_SH4:     res = (src1 << 4) + src2;
         OPC_SUB:     res = diff[DATA_W-1:0];
         OPC_LT_U:    res = {{(DATA_W-1){1'b0}}, lt_u};
         OPC_LT_S:    res = {{(DATA_W-1){1'b0}}, lt_s};
         OPC_MAX_U:   res = lt_u ? src2 : src1;
         OPC_MIN_U:   res = lt_u ? src1 : src2;
         OPC_MAX_S:   res = lt_s ? src2 : src1;
         OPC_MIN_S:   res = lt_s ? src1 : src2;
         default:     hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
   import fused_alu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  opc_t              op,
   input  logic [DATA_W-1:0] src1,
   input  logic [DATA_W-1:0] src2,
   output logic              hit,
   output logic [DATA_W-1:0] res
);
   localparam int BYTES  = DATA_W / 8;
   localparam int HALF_W = DATA_W / 2;
   localparam int HW_W   = 16;
   localparam int BY_W   = 8;

   logic [DATA_W-1:0] byte_or, bit_rev, byte_rev, nar_base;
   logic              nar_ok;

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign byte_or[b*BY_W +: BY_W]  = {BY_W{|src1[b*BY_W +: BY_W]}};
      assign byte_rev[b*BY_W +: BY_W] = src1[(BYTES-1-b)*BY_W +: BY_W];
      for (genvar i = 0; i < BY_W; i++) begin : g_bit
         assign bit_rev[b*BY_W + i] = src1[b*BY_W + BY_W-1-i];
      end
   end

   // base operation for the narrowed group, picked by code bits [3:1]
   always_comb begin
      nar_ok = 1'b1;
      unique case (op[3:1])
         3'b000:  nar_base = src1 & src2;
         3'b001:  nar_base = src1 | src2;
         3'b010:  nar_base = src1 ^ src2;
         3'b011:  nar_base = byte_or;
         default: begin
            nar_base = '0;
            nar_ok   = 1'b0;
         end
      endcase
   end

   always_comb begin
      hit = 1'b1;
      res = '0;
      if (op[6:4] == GRP_NARROW) begin
         hit = nar_ok;
         res = op[0] ? {{(DATA_W-HW_W){1'b0}}, nar_base[HW_W-1:0]}
                     : {{(DATA_W-1){1'b0}}, nar_base[0]};
      end else begin
         unique case (op)
            OPC_AND:     res = src1 & src2;
            OPC_ANDNOT:  res = src1 & ~src2;
            OPC_OR:      res = src1 | src2;
            OPC_ORNOT:   res = src1 | ~src2;
            OPC_XOR:     res = src1 ^ src2;
            OPC_XNOR:    res = ~(src1 ^ src2);
            OPC_BYTEOR:  res = byte_or;
            OPC_SEXT8:   res = {{(DATA_W-BY_W){src1[BY_W-1]}}, src1[BY_W-1:0]};
            OPC_SEXT16:  res = {{(DATA_W-HW_W){src1[HW_W-1]}}, src1[HW_W-1:0]};
            OPC_PACK8:   res = {{(DATA_W-2*BY_W){1'b0}}, src2[BY_W-1:0], src1[BY_W-1:0]};
            OPC_PACK16:  res = {{(DATA_W-HALF_W){src2[HW_W-1]}}, src2[HW_W-1:0], src1[HW_W-1:0]};
            OPC_PACK32:  res = {src2[HALF_W-1:0], src1[HALF_W-1:0]};
            OPC_BITREV:  res = bit_rev;
            OPC_BYTEREV: res = byte_rev;
            default:     hit = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/fused_int_alu.sv
module fused_int_alu
   import fused_alu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [6:0]        in_op,
   input  logic [DATA_W-1:0] in_src1,
   input  logic [DATA_W-1:0] in_src2,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result
);
   localparam int SH_W   = $clog2(DATA_W);
   localparam int HALF_W = DATA_W / 2;

   if (DATA_W != 64) begin : g_width_check
      $error("fused_int_alu: DATA_W must be 64, the word and fused encodings assume it");
   end
   if (OPC_W != 7) begin : g_opc_check
      $error("fused_int_alu: operation code must be 7 bits");
   end

   logic              hit_sh, hit_ar, hit_lg;
   logic [DATA_W-1:0] res_sh, res_ar, res_lg, res_all;

   alu_shift_unit #(.DATA_W(DATA_W)) u_shift (
      .op   (in_op),
      .src1 (in_src1),
      .amt  (in_src2[SH_W-1:0]),
      .hit  (hit_sh),
      .res  (res_sh)
   );

   alu_arith_unit #(.DATA_W(DATA_W)) u_arith (
      .op   (in_op),
      .src1 (in_src1),
      .src2 (in_src2),
      .hit  (hit_ar),
      .res  (res_ar)
   );

   alu_logic_unit #(.DATA_W(DATA_W)) u_logic (
      .op   (in_op),
      .src1 (in_src1),
      .src2 (in_src2),
      .hit  (hit_lg),
      .res  (res_lg)
   );

   // each unit drives zero for codes it does not own, so an OR merges them
   assign res_all = res_sh | res_ar | res_lg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_result <= res_all;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                             // R1
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                                           // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result));                                  // R2
   AST_WORD_SIGNEXT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_op == OPC_W_ADD || in_op == OPC_W_SUB || in_op == OPC_W_SLL ||
                   in_op == OPC_W_SRL || in_op == OPC_W_SRA)
      |=> out_result[DATA_W-1:HALF_W] == {HALF_W{out_result[HALF_W-1]}}); // R5
   AST_CMP_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_op == OPC_LT_U || in_op == OPC_LT_S)
      |=> out_result[DATA_W-1:1] == '0);                                   // R10
   AST_NARROW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_op[6:4] == GRP_NARROW && !in_op[0]
      |=> out_result[DATA_W-1:1] == '0);                                   // R12
   AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_sh, hit_ar, hit_lg}));                                 // R13
   AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !(hit_sh || hit_ar || hit_lg) |=> out_result == '0);     // R13

endmodule

// File: tb/fused_int_alu_bench.sv
`timescale 1ns/1ps
module fused_int_alu_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [6:0]  in_op = '0;
   logic [63:0] in_src1 = '0;
   logic [63:0] in_src2 = '0;
   logic        out_valid;
   logic [63:0] out_result;

   int n_total = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;   // 250 MHz

   fused_int_alu u_fused_int_alu (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_src1(in_src1), .in_src2(in_src2),
      .out_valid(out_valid), .out_result(out_result)
   );

   typedef struct packed {
      logic [6:0]  op;
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 18;
   localparam vec_t VECS [NVEC] = '{
      '{7'b0011010, 64'h0000_0000_8000_0000, 64'd4, 64'hFFFF_FFFF_F800_0000, 4'd5},   // R5 word arith shift
      '{7'b0100011, 64'd0, 64'h0000_0000_1234_5FFF, 64'h0000_0000_1234_4FFF, 4'd9},  // R9
      '{7'b0010011, 64'd0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_8000_0000, 4'd9},  // R9 word form
      '{7'b0110010, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd1, 4'd10},                   // R10 signed lt
      '{7'b0110001, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 4'd10},                   // R10 unsigned lt
      '{7'b0110111, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 4'd10}, // R10 signed min
      '{7'b0100010, 64'd3, 64'd10, 64'd11, 4'd7},                                    // R7 odd add
      '{7'b0100111, 64'hFFFF_FFFF_0000_0000, 64'd1, 64'h0000_0001_0000_0000, 4'd7},  // R7 shift by 32
      '{7'b0000110, 64'h8000_0000_0000_0000, 64'h7F, 64'd1, 4'd4},                   // R4 index wraps to 63
      '{7'b1100011, 64'hFFFF_0000_0001_0000, 64'h0F0F, 64'h0F0F, 4'd12},             // R12 or, halfword
      '{7'b1100000, 64'd3, 64'd1, 64'd1, 4'd12},                                     // R12 and, bit 0
      '{7'b0101100, 64'hFFFF_FFFF_0000_0001, 64'd2, 64'd10, 4'd8},                   // R8 uw variant
      '{7'b0001001, 64'h8000_0000_0000_0001, 64'd1, 64'd3, 4'd3},                    // R3 rotate
      '{7'b0010111, 64'h7FFF, 64'd1, 64'hFFFF_FFFF_FFFF_8000, 4'd6},                 // R6 halfword sign
      '{7'b1111111, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 4'd13}, // R13
      '{7'b1000110, 64'h0001_0000_0000_0100, 64'd0, 64'h00FF_0000_0000_FF00, 4'd11}, // R11 byte or
      '{7'b1001011, 64'h1234, 64'h8765, 64'hFFFF_FFFF_8765_1234, 4'd11},             // R11 pack
      '{7'b1010001, 64'h0102_0304_0506_0708, 64'd0, 64'h0807_0605_0403_0201, 4'd11}  // R11 byte order
   };

   function automatic logic [63:0] sx32(input logic [31:0] v);
      return {{32{v[31]}}, v};
   endfunction

   function automatic logic [63:0] orcomb(input logic [63:0] v);
      logic [63:0] r;
      for (int k = 0; k < 8; k++) r[8*k +: 8] = (v[8*k +: 8] != 0) ? 8'hFF : 8'h00;
      return r;
   endfunction

   // behavioural model built from the requirement text
   function automatic logic [63:0] model(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
      logic [63:0] r, s, base;
      int n, wn;
      logic [31:0] w;
      n  = int'(b[5:0]);
      wn = int'(b[4:0]);
      s  = a + b;
      r  = 64'd0;
      case (op)
         7'b0000000: r = {32'd0, a[31:0]} << n;
         7'b0000001: r = a << n;
         7'b0000101: r = a >> n;
         7'b0000111: r = 64'($signed(a) >>> n);
         7'b0001001: for (int k = 0; k < 64; k++) r[(k+n)%64] = a[k];
         7'b0001011: for (int k = 0; k < 64; k++) r[k] = a[(k+n)%64];
         7'b0000010: begin r = a; r[n] = 1'b0; end
         7'b0000011: begin r = a; r[n] = 1'b1; end
         7'b0000100: begin r = a; r[n] = ~a[n]; end
         7'b0000110: r = {63'd0, a[n]};
         7'b0010000: r = sx32(s[31:0]);
         7'b0010001: r = sx32(32'(b + {63'd0, a[0]}));
         7'b0010010: r = sx32(32'(a - b));
         7'b0010011: r = sx32(32'(32'($signed(b[11:0])) + {b[31:12], 12'd0}));
         7'b0010100: r = {63'd0, s[0]};
         7'b0010101: r = {56'd0, s[7:0]};
         7'b0010110: r = {48'd0, s[15:0]};
         7'b0010111: r = 64'($signed(s[15:0]));
         7'b0011000: r = sx32(a[31:0] << wn);
         7'b0011001: r = sx32(a[31:0] >> wn);
         7'b0011010: r = sx32(32'($signed(a[31:0]) >>> wn));
         7'b0011100: begin w = '0; for (int k = 0; k < 32; k++) w[(k+wn)%32] = a[k]; r = sx32(w); end
         7'b0011101: begin w = '0; for (int k = 0; k < 32; k++) w[k] = a[(k+wn)%32]; r = sx32(w); end
         7'b0100000: r = {32'd0, a[31:0]} + b;
         7'b0100001: r = s;
         7'b0100010: r = {63'd0, a[0]} + b;
         7'b0100011: r = 64'($signed(b[11:0])) + {b[63:12], 12'd0};
         7'b0100100: r = (a >> 29) + b;
         7'b0100101: r = (a >> 30) + b;
         7'b0100110: r = (a >> 31) + b;
         7'b0100111: r = (a >> 32) + b;
         7'b0101000: r = ({32'd0, a[31:0]} << 1) + b;
         7'b0101001: r = (a << 1) + b;
         7'b0101010: r = ({32'd0, a[31:0]} << 2) + b;
         7'b0101011: r = (a << 2) + b;
         7'b0101100: r = ({32'd0, a[31:0]} << 3) + b;
         7'b0101101: r = (a << 3) + b;
         7'b0101111: r = (a << 4) + b;
         7'b0110000: r = a - b;
         7'b0110001: r = (a < b) ? 64'd1 : 64'd0;
         7'b0110010: r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
         7'b0110100: r = (a > b) ? a : b;
         7'b0110101: r = (a < b) ? a : b;
         7'b0110110: r = ($signed(a) > $signed(b)) ? a : b;
         7'b0110111: r = ($signed(a) < $signed(b)) ? a : b;
         7'b1000000: r = a & b;
         7'b1000001: r = a & ~b;
         7'b1000010: r = a | b;
         7'b1000011: r = a | ~b;
         7'b1000100: r = a ^ b;
         7'b1000101: r = ~(a ^ b);
         7'b1000110: r = orcomb(a);
         7'b1001000: r = 64'($signed(a[7:0]));
         7'b1001001: r = {48'd0, b[7:0], a[7:0]};
         7'b1001010: r = 64'($signed(a[15:0]));
         7'b1001011: r = sx32({b[15:0], a[15:0]});
         7'b1010000: for (int k = 0; k < 64; k++) r[k] = a[(k/8)*8 + 7 - (k%8)];
         7'b1010001: for (int k = 0; k < 8; k++) r[8*k +: 8] = a[8*(7-k) +: 8];
         7'b1010010: r = {b[31:0], a[31:0]};
         default: begin
            if (op[6:4] == 3'b110 && op[3] == 1'b0) begin
               case (op[2:1])
                  2'b00:   base = a & b;
                  2'b01:   base = a | b;
                  2'b10:   base = a ^ b;
                  default: base = orcomb(a);
               endcase
               r = op[0] ? {48'd0, base[15:0]} : {63'd0, base[0]};
            end
         end
      endcase
      return r;
   endfunction

   function automatic string req_of(input logic [6:0] op);
      case (op[6:4])
         3'b000: return (op[2:0] == 3'b010 || op[2:0] == 3'b011 || op[2:0] == 3'b100 ||
                         op[2:0] == 3'b110) && !op[3] ? "R4" : "R3";
         3'b001: return (op[3:2] == 2'b01) ? "R6" : "R5";
         3'b010: return (op == 7'b0100011) ? "R9" : (op[3] ? "R8" : "R7");
         3'b011: return "R10";
         3'b110: return "R12";
         3'b111: return "R13";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_src1 = a; in_src2 = b;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [63:0] held;
      logic [63:0] pa [4];
      logic [63:0] pb [4];

      // R1 reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1", "reset valid", {63'd0, out_valid}, 64'd0);
      check("R1", "reset result", out_result, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 one-cycle latency
      issue(7'b0100001, 64'd5, 64'd7);
      check("R1", "valid after issue", {63'd0, out_valid}, 64'd1);
      check("R1", "result after issue", out_result, 64'd12);

      // R2 hold while idle, with changing inputs
      held = out_result;
      @(negedge clk);
      in_valid = 1'b0; in_op = 7'b0110000; in_src1 = 64'hDEAD; in_src2 = 64'h1;
      @(posedge clk); #1;
      check("R2", "idle valid", {63'd0, out_valid}, 64'd0);
      check("R2", "idle hold", out_result, held);
      @(negedge clk);
      in_op = 7'b1000101; in_src1 = 64'h1234;
      @(posedge clk); #1;
      check("R2", "idle hold 2", out_result, held);

      // directed vector table
      for (int i = 0; i < NVEC; i++) begin
         issue(VECS[i].op, VECS[i].a, VECS[i].b);
         check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d op %b", i, VECS[i].op),
               out_result, VECS[i].exp);
      end

      // sweep every code against the model (R3 to R13)
      for (int op = 0; op < 128; op++) begin
         pa[0] = 64'd0;                 pb[0] = 64'hFFFF_FFFF_FFFF_FFFF;
         pa[1] = 64'hFFFF_FFFF_FFFF_FFFF; pb[1] = 64'h0000_0000_0000_00E3;
         pa[2] = {$urandom, $urandom};  pb[2] = {$urandom, $urandom};
         pa[3] = {1'b1, 31'($urandom), $urandom}; pb[3] = {1'b0, 31'($urandom), $urandom};
         for (int k = 0; k < 4; k++) begin
            issue(7'(op), pa[k], pb[k]);
            check(req_of(7'(op)), $sformatf("op %b pair %0d", 7'(op), k),
                  out_result, model(7'(op), pa[k], pb[k]));
         end
      end

      // R1 reset in the middle of traffic
      issue(7'b1000010, 64'hF0, 64'h0F);
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk); #1;
      check("R1", "mid reset valid", {63'd0, out_valid}, 64'd0);
      check("R1", "mid reset result", out_result, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      in_valid = 1'b0;
      @(posedge clk); #1;
      check("R2", "idle after reset", {63'd0, out_valid}, 64'd0);

      finish_run();
   end

endmodule